// File: doc/BRIEF.md
# Serial DAC command front end

This block is the digital side of a 14-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The top two bits of each word are an opcode. Depending on the opcode, the block fills a staging (input) register, moves a value into the live DAC register, or runs a control sub-command. The control sub-commands are a no-op, sleep, driving a general-purpose output pin, and choosing the phase of the serial output. All serial pins are resynchronised into a faster system clock, and all edges are found there.

The serial output is the end of the receive shift register. Several parts can therefore be chained, and a host can read back what it shifted in. In the default phase it trails the input by 16 serial clocks. In the alternate phase, a stage clocked on the falling serial edge adds half a clock, for a total lag of 16.5. A word takes effect only when select returns high after exactly 16 clocked bits. Any other count is thrown away.

Top module: `serdac_front`

## Requirements
- R1: After reset, the staging code and DAC code are 0, `sleep` is 0, `user_out` is 0, the default output phase is active and `sdo` is 0.
- R2: While `sel_n` is low, each rising `sck` edge shifts `sdi` into the word, first bit into bit 15 (MSB first). Bits 15:14 are the opcode and bits 13:0 are the data.
- R3: Opcode 00 writes data into the staging code and leaves the DAC code unchanged.
- R4: Opcode 01 writes data into both the staging code and the DAC code, and clears `sleep`.
- R5: Opcode 10 copies the staging code into the DAC code, ignores the data bits and clears `sleep`.
- R6: A frame whose count of rising `sck` edges with select low is not 16 changes nothing when `sel_n` rises.
- R7: A 16-bit frame sent as two 8-bit bursts with `sel_n` held low acts the same as one burst.
- R8: With opcode 11, sub-field bits 13:12 = 01 sets `sleep` only if `sleep_allow` is 1. Otherwise it has no effect.
- R9: With opcode 11 and bits 13:12 = 10, bit 11 is written to `user_out`.
- R10: With opcode 11 and bits 13:12 = 11, bit 11 = 1 selects the default phase and bit 11 = 0 selects the half-clock-delayed phase.
- R11: In the default phase, `sdo` shows the bit shifted 16 rising edges earlier. In the delayed phase, `sdo` changes on falling `sck` edges and lags by 16.5 clocks.
- R12: While `sleep` is 1, `sdo` holds the value it had when sleep began.
- R13: Opcode 11 with bits 13:12 = 00 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| sel_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sleep_allow | input | 1 | Permits the sleep sub-command when high |
| sdo | output | 1 | Serial data out (shift-register tail) |
| hold_code | output | 14 | Staging register |
| dac_code | output | 14 | Live DAC register |
| sleep | output | 1 | Converter in sleep |
| user_out | output | 1 | General-purpose logic output |

## Verification
Several properties are checked on every cycle:
- The DAC code changes only one cycle after an accepted frame with an updating opcode.
- The staging code changes only after a loading opcode.
- Sleep starts only while `sleep_allow` was high, and ends only on a DAC update.
- The bit counter never exceeds its cap.
- `sdo` stays frozen through sleep.

The bench scenarios are needed for the rest:
- the exact 16 and 16.5 clock lag of `sdo` in each phase;
- the rejection of 15-bit and 17-bit frames;
- the split-burst frame;
- the decoding of each sub-command's argument bit.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
   localparam int OP_W = 2;

   typedef enum logic [1:0] {
      OP_STAGE    = 2'b00,
      OP_STAGE_GO = 2'b01,
      OP_GO       = 2'b10,
      OP_CTRL     = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      CT_IDLE  = 2'b00,
      CT_SLEEP = 2'b01,
      CT_PIN   = 2'b10,
      CT_PHASE = 2'b11
   } ctl_e;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
   parameter int          W      = 3,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
   parameter int FRAME_W       = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit HALF_STAGE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               sel_n,
   input  logic               sdi,
   input  logic               half_mode,
   input  logic               sleep,
   output logic               frame_ok,
   output logic [FRAME_W-1:0] frame_word,
   output logic               sdo
);
   localparam int                CNT_W    = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0]  CNT_CAP  = CNT_W'(FRAME_W + 1);

   logic [2:0] pins_s;
   logic       sck_s, sel_s, sdi_s;
   logic       sck_d, sel_d;
   logic       sck_rise, sck_fall, sel_rise;
   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               tail_src;
   logic               sdo_q;

   serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck, sel_n, sdi}),
      .q     (pins_s)
   );
   assign {sck_s, sel_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         sel_d <= 1'b1;
      end else begin
         sck_d <= sck_s;
         sel_d <= sel_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;
   assign sel_rise = sel_s & ~sel_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         cnt_q    <= '0;
         frame_ok <= 1'b0;
      end else begin
         frame_ok <= 1'b0;
         if (sel_rise) begin
            frame_ok <= (cnt_q == CNT_FULL);
            cnt_q    <= '0;
         end else if (sck_rise && !sel_s) begin
            sr_q  <= {sr_q[FRAME_W-2:0], sdi_s};
            cnt_q <= (cnt_q == CNT_CAP) ? cnt_q : cnt_q + 1'b1;
         end
      end
   end

   assign frame_word = sr_q;

   generate
      if (HALF_STAGE_EN) begin : g_half
         logic half_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        half_q <= 1'b0;
            else if (sck_fall) half_q <= sr_q[FRAME_W-1];
         end
         assign tail_src = half_mode ? half_q : sr_q[FRAME_W-1];
      end else begin : g_plain
         logic unused_half;
         assign unused_half = half_mode;
         assign tail_src    = sr_q[FRAME_W-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sdo_q <= 1'b0;
      else if (!sleep) sdo_q <= tail_src;
   end
   assign sdo = sdo_q;

   p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_CAP);
   p_ok_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> !frame_ok);
   p_sdo_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && $past(sleep)) |-> $stable(sdo_q));
endmodule

// File: rtl/serdac_regs.sv
module serdac_regs
   import serdac_pkg::*;
#(
   parameter int DATA_W  = 14,
   parameter int FRAME_W = DATA_W + OP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_ok,
   input  logic [FRAME_W-1:0] frame_word,
   input  logic               sleep_allow,
   output logic [DATA_W-1:0]  hold_code,
   output logic [DATA_W-1:0]  dac_code,
   output logic               sleep,
   output logic               user_out,
   output logic               half_mode
);
   op_e               op;
   ctl_e              ct;
   logic              arg;
   logic [DATA_W-1:0] payload;

   assign op      = op_e'(frame_word[FRAME_W-1 -: OP_W]);
   assign ct      = ctl_e'(frame_word[DATA_W-1 -: 2]);
   assign arg     = frame_word[DATA_W-3];
   assign payload = frame_word[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_code <= '0;
         dac_code  <= '0;
         sleep     <= 1'b0;
         user_out  <= 1'b0;
         half_mode <= 1'b0;
      end else if (frame_ok) begin
         unique case (op)
            OP_STAGE: hold_code <= payload;
            OP_STAGE_GO: begin
               hold_code <= payload;
               dac_code  <= payload;
               sleep     <= 1'b0;
            end
            OP_GO: begin
               dac_code <= hold_code;
               sleep    <= 1'b0;
            end
            OP_CTRL: begin
               unique case (ct)
                  CT_IDLE:  ;
                  CT_SLEEP: if (sleep_allow) sleep <= 1'b1;
                  CT_PIN:   user_out  <= arg;
                  CT_PHASE: half_mode <= ~arg;
               endcase
            end
         endcase
      end
   end

   p_dac_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> $past(frame_ok && (op == OP_STAGE_GO || op == OP_GO)));
   p_hold_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hold_code) |-> $past(frame_ok && (op == OP_STAGE || op == OP_STAGE_GO)));
   p_sleep_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep) |-> $past(sleep_allow));
   p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> $past(frame_ok && (op == OP_STAGE_GO || op == OP_GO)));
endmodule

// File: rtl/serdac_front.sv
module serdac_front
   import serdac_pkg::*;
#(
   parameter int DATA_W        = 14,
   parameter int SYNC_STAGES   = 2,
   parameter bit HALF_STAGE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              sel_n,
   input  logic              sdi,
   input  logic              sleep_allow,
   output logic              sdo,
   output logic [DATA_W-1:0] hold_code,
   output logic [DATA_W-1:0] dac_code,
   output logic              sleep,
   output logic              user_out
);
   localparam int FRAME_W = DATA_W + OP_W;

   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("serdac_front: DATA_W must leave room for a sub-command and its argument");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serdac_front: SYNC_STAGES below 2 is not a safe synchronizer");
      end
   endgenerate

   logic               frame_ok;
   logic [FRAME_W-1:0] frame_word;
   logic               half_mode;

   serdac_shifter #(
      .FRAME_W       (FRAME_W),
      .SYNC_STAGES   (SYNC_STAGES),
      .HALF_STAGE_EN (HALF_STAGE_EN)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck        (sck),
      .sel_n      (sel_n),
      .sdi        (sdi),
      .half_mode  (half_mode),
      .sleep      (sleep),
      .frame_ok   (frame_ok),
      .frame_word (frame_word),
      .sdo        (sdo)
   );

   serdac_regs #(
      .DATA_W  (DATA_W),
      .FRAME_W (FRAME_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_ok    (frame_ok),
      .frame_word  (frame_word),
      .sleep_allow (sleep_allow),
      .hold_code   (hold_code),
      .dac_code    (dac_code),
      .sleep       (sleep),
      .user_out    (user_out),
      .half_mode   (half_mode)
   );
endmodule

// File: tb/tb_serdac_front.sv
module tb_serdac_front;
   localparam int CLK_P = 10;
   localparam int HALF  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, sel_n = 1'b1, sdi = 1'b0, sleep_allow = 1'b0;
   logic        sdo, sleep, user_out;
   logic [13:0] hold_code, dac_code;

   serdac_front dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .sdi(sdi),
      .sleep_allow(sleep_allow), .sdo(sdo), .hold_code(hold_code),
      .dac_code(dac_code), .sleep(sleep), .user_out(user_out)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit          hist[$];
   int          m_hold = 0, m_dac = 0;
   bit          m_sleep = 0, m_pin = 0, m_half = 0, m_held = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit tail(input int lag);
      int idx = hist.size() - lag;
      return (idx >= 0) ? hist[idx] : 1'b0;
   endfunction

   function automatic bit exp_sdo(input bit high_phase);
      if (m_sleep) return m_held;
      if (high_phase && m_half) return tail(17);
      return tail(16);
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      sdi = b;
      cyc(HALF);
      sck = 1'b1;
      hist.push_back(b);
      cyc(HALF - 1);
      chk("R11 sdo after rising edge", int'(sdo), int'(exp_sdo(1'b1)));
      cyc(1);
      sck = 1'b0;
      cyc(HALF - 1);
      chk("R11 sdo after falling edge", int'(sdo), int'(exp_sdo(1'b0)));
      cyc(1);
   endtask

   task automatic model_exec(input logic [15:0] w);
      case (w[15:14])
         2'b00: m_hold = int'(w[13:0]);
         2'b01: begin m_hold = int'(w[13:0]); m_dac = m_hold; m_sleep = 0; end
         2'b10: begin m_dac = m_hold; m_sleep = 0; end
         default: case (w[13:12])
            2'b01: if (sleep_allow && !m_sleep) begin m_held = tail(16); m_sleep = 1; end
            2'b10: m_pin  = w[11];
            2'b11: m_half = ~w[11];
            default: ;
         endcase
      endcase
   endtask

   task automatic check_regs(input string req);
      chk({req, " hold_code"}, int'(hold_code), m_hold);
      chk({req, " dac_code"},  int'(dac_code),  m_dac);
      chk({req, " sleep"},     int'(sleep),     int'(m_sleep));
      chk({req, " user_out"},  int'(user_out),  int'(m_pin));
      chk({req, " idle sdo"},  int'(sdo),       int'(exp_sdo(1'b0)));
   endtask

   task automatic frame(input logic [15:0] w, input int nbits, input bit split, input string req);
      sel_n = 1'b0;
      cyc(HALF);
      for (int i = 0; i < nbits; i++) begin
         send_bit((i < 16) ? w[15-i] : 1'b0);
         if (split && i == 7) cyc(40);
      end
      cyc(HALF);
      sel_n = 1'b1;
      cyc(10);
      if (nbits == 16) model_exec(w);
      check_regs(req);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(4);
      // R1 reset state
      check_regs("R1 reset");

      frame(16'h1234, 16, 1'b0, "R3 stage only");            // R2 MSB-first assembly too
      frame(16'h8ABC, 16, 1'b0, "R5 go copies staging");
      frame(16'h6AAA, 16, 1'b0, "R4 stage and go");
      frame(16'h0F0F, 16, 1'b1, "R7 split bursts");
      frame(16'h7FFF, 15, 1'b0, "R6 short frame dropped");
      frame(16'h7FFF, 17, 1'b0, "R6 long frame dropped");
      frame(16'hC5A5, 16, 1'b0, "R13 idle sub-command");
      sleep_allow = 1'b0;
      frame(16'hD000, 16, 1'b0, "R8 sleep blocked");
      sleep_allow = 1'b1;
      frame(16'hD000, 16, 1'b0, "R8 sleep allowed");
      frame(16'h0555, 16, 1'b0, "R12 staging load during sleep");
      frame(16'h3333, 16, 1'b1, "R12 sdo held during sleep");
      frame(16'h8000, 16, 1'b0, "R5 go wakes");
      frame(16'hD7FF, 16, 1'b0, "R8 sleep again");
      frame(16'h4321, 16, 1'b0, "R4 stage and go wakes");
      frame(16'hE800, 16, 1'b0, "R9 user_out high");
      frame(16'hE000, 16, 1'b0, "R9 user_out low");
      frame(16'hE9FF, 16, 1'b0, "R9 user_out high again");
      frame(16'hF000, 16, 1'b0, "R10 select delayed phase");
      frame(16'h1357, 16, 1'b0, "R11 delayed phase lag");
      frame(16'h2C6A, 16, 1'b1, "R11 delayed phase split");
      frame(16'hF800, 16, 1'b0, "R10 select default phase");
      frame(16'h29D3, 16, 1'b0, "R11 default phase lag");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      checks++;
      fails++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule